// File: doc/BRIEF.md
# Double-Pumped Dual Integer ALU

This block holds two integer execution lanes that run on a fast clock at twice the rate of the main pipeline clock. An internal phase bit divides each main clock into a first half and a second half. An issuer that runs at the main clock presents up to two operations per main clock, on slot 0 and slot 1. Each slot carries an opcode, two operand values and a destination tag. Slot 1 can also set a dependency flag. When it does, its first operand is taken from the slot 0 result instead of its own A field.

Simple operations (add, subtract, and, or, xor, move) are computed in the first half of the main clock. A dependent simple operation on slot 1 picks up the slot 0 half-cycle result and is computed in the second half, so both operations of the pair complete in the same main clock. Shifts occupy a full main clock, so they must start in the first half. For this reason slot 1 is refused when its dependency would force a shift to start late, or when it needs a result that does not exist in time. The issuer then holds that operation and sends it again in the next main clock.

Both slots are sampled at the fast clock edge that ends a second half. Slot 0 follows a plain valid protocol and is always accepted. Slot 1 follows valid/ready: the operation is taken only when `s1_valid` and `s1_ready` are both high at that sampling edge. `s1_ready` is decided from the current slot contents alone, so an operation that is held back keeps its fields stable and is sent again. Each lane drives a result strobe with the result value and the destination tag. Because the block sits in a pipeline and always moves forward, the result side has no back-pressure.

Top module: `dual_pump_alu`

## Requirements
- R1: An operation accepted at a main clock edge (a fast edge where `half_phase` is 1) shows its result, tag and a high valid strobe on its lane at the next main clock edge. These values hold for exactly one main clock, which is two fast cycles. With no accepted operation, the lane's valid strobe is low for that main clock.
- R2: Opcode encodings on 3 bits: 0 add, 1 subtract (A minus B, wrapping), 2 and, 3 or, 4 xor, 7 move (result is A). All arithmetic is modulo 2^DATA_W.
- R3: Opcode 5 is a logical left shift and opcode 6 a logical right shift of A. The shift amount is the low log2(DATA_W) bits of B, and the upper bits of B are ignored.
- R4: When slot 1 is accepted with `s1_dep` high, its A operand is the slot 0 result from the same main clock and its own A field is ignored. Both results appear at the same main clock edge.
- R5: `s1_ready` is low when `s1_dep` is high and any of these holds: slot 0 is not valid, slot 0 is a shift, or slot 1 is a shift. A refused slot 1 operation produces no result.
- R6: `s1_ready` is high whenever `s1_dep` is low, whatever the two opcodes. Slot 0 is always accepted when valid.
- R7: `half_phase` is 0 in the first half and 1 in the second half of each main clock. It toggles on every fast clock edge out of reset.
- R8: A synchronous reset `rst` discards in-flight operations, drives both valid strobes low and restarts in the first half.
- R9: Two new operations can be accepted at every main clock, back to back, with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the main clock rate |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Slot 0 holds an operation |
| s0_op | input | 3 | Slot 0 opcode |
| s0_a | input | DATA_W | Slot 0 operand A |
| s0_b | input | DATA_W | Slot 0 operand B |
| s0_tag | input | TAG_W | Slot 0 destination tag |
| s1_valid | input | 1 | Slot 1 holds an operation |
| s1_op | input | 3 | Slot 1 opcode |
| s1_a | input | DATA_W | Slot 1 operand A (ignored when dependent) |
| s1_b | input | DATA_W | Slot 1 operand B |
| s1_tag | input | TAG_W | Slot 1 destination tag |
| s1_dep | input | 1 | Slot 1 takes the slot 0 result as operand A |
| s1_ready | output | 1 | Slot 1 can be accepted at this main clock edge |
| half_phase | output | 1 | 1 during the second half of the main clock |
| r0_valid | output | 1 | Lane 0 result strobe |
| r0_data | output | DATA_W | Lane 0 result |
| r0_tag | output | TAG_W | Lane 0 destination tag |
| r1_valid | output | 1 | Lane 1 result strobe |
| r1_data | output | DATA_W | Lane 1 result |
| r1_tag | output | TAG_W | Lane 1 destination tag |

## Verification
Directed pairs run every opcode on both lanes. Shift amounts are set to 0 and to the maximum, with the upper bits of B set, so that a missing mask or a swapped direction shows up. Dependent pairs put a wrong value in the slot 1 A field, which separates true forwarding from a plain read of the field. Each refusal condition is tried on its own: slot 0 invalid, a slot 0 shift, and a slot 1 shift. This catches a ready decode that omits one of the terms. A seeded random stream then issues back-to-back pairs with mixed dependencies and valid gaps, and a reset in the middle of a run shows that in-flight results are discarded.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_MOV = 3'd7
  } op_e;

  // Full-cycle operations: must start in the first half.
  function automatic logic op_is_shift(input logic [2:0] op);
    return (op == OP_SHL) || (op == OP_SHR);
  endfunction

endpackage

// File: rtl/dpa_simple_unit.sv
module dpa_simple_unit
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  // Half-cycle datapath; shift codes fall to the move path and are unused.
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/dpa_shift_unit.sv
module dpa_shift_unit #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic            left,
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    y
);

  always_comb begin
    if (left) y = a << amt;
    else      y = a >> amt;
  end

endmodule

// File: rtl/dpa_issue_gate.sv
module dpa_issue_gate
  import dpa_pkg::*;
(
  input  logic       s0_valid,
  input  logic [2:0] s0_op,
  input  logic [2:0] s1_op,
  input  logic       s1_dep,
  output logic       s1_ready
);

  logic late_start;   // dependent shift would have to begin in the second half
  logic no_producer;  // forwarded value missing or not ready by mid-cycle

  always_comb begin
    late_start  = op_is_shift(s1_op);
    no_producer = !s0_valid || op_is_shift(s0_op);
    s1_ready    = !(s1_dep && (late_start || no_producer));
  end

endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
#(
  parameter int W     = 32,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             second_half,
  input  logic             take,
  input  logic [2:0]       op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [TAG_W-1:0] tag,
  input  logic             dep,
  input  logic [W-1:0]     fwd_data,
  output logic [W-1:0]     half_res,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [TAG_W-1:0] out_tag
);

  localparam int SH_W = $clog2(W);

  logic             st_v;
  logic             st_dep;
  logic [2:0]       st_op;
  logic [W-1:0]     st_a;
  logic [W-1:0]     st_b;
  logic [TAG_W-1:0] st_tag;
  logic [W-1:0]     half_q;

  logic [W-1:0] early_y;
  logic [W-1:0] late_y;
  logic [W-1:0] sh_y;
  logic [W-1:0] final_y;

  // First half: own operands.
  dpa_simple_unit #(.W(W)) u_early (
    .op(st_op), .a(st_a), .b(st_b), .y(early_y)
  );

  // Second half: forwarded operand A.
  dpa_simple_unit #(.W(W)) u_late (
    .op(st_op), .a(fwd_data), .b(st_b), .y(late_y)
  );

  // Full cycle: operands held over both halves.
  dpa_shift_unit #(.W(W), .SH_W(SH_W)) u_shift (
    .left(st_op == OP_SHL), .a(st_a), .amt(st_b[SH_W-1:0]), .y(sh_y)
  );

  always_comb begin
    if (op_is_shift(st_op)) final_y = sh_y;
    else if (st_dep)        final_y = late_y;
    else                    final_y = half_q;
  end

  assign half_res = half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v      <= 1'b0;
      st_dep    <= 1'b0;
      st_op     <= OP_ADD;
      st_a      <= '0;
      st_b      <= '0;
      st_tag    <= '0;
      half_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else if (second_half) begin
      // main clock edge: retire the current op, capture the next
      out_valid <= st_v;
      out_data  <= final_y;
      out_tag   <= st_tag;
      st_v      <= take;
      st_dep    <= take && dep;
      if (take) begin
        st_op  <= op;
        st_a   <= a;
        st_b   <= b;
        st_tag <= tag;
      end
    end else begin
      half_q <= early_y;
    end
  end

  // Result strobe follows the in-flight op by one main clock.
  assert_result_R1: assert property (@(posedge clk) disable iff (rst)
    second_half |=> (out_valid == $past(st_v)));

  // Outputs hold through the first half of the following main clock.
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    second_half |-> ($stable(out_valid) && $stable(out_tag) && $stable(out_data)));

  // A dependent op in flight is never a shift and is always a live op.
  assert_dep_simple_R5: assert property (@(posedge clk) disable iff (rst)
    st_dep |-> (st_v && !op_is_shift(st_op)));

  assert_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !st_v));

endmodule

// File: rtl/dual_pump_alu.sv
module dual_pump_alu
  import dpa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s0_valid,
  input  logic [2:0]        s0_op,
  input  logic [DATA_W-1:0] s0_a,
  input  logic [DATA_W-1:0] s0_b,
  input  logic [TAG_W-1:0]  s0_tag,
  input  logic              s1_valid,
  input  logic [2:0]        s1_op,
  input  logic [DATA_W-1:0] s1_a,
  input  logic [DATA_W-1:0] s1_b,
  input  logic [TAG_W-1:0]  s1_tag,
  input  logic              s1_dep,
  output logic              s1_ready,
  output logic              half_phase,
  output logic              r0_valid,
  output logic [DATA_W-1:0] r0_data,
  output logic [TAG_W-1:0]  r0_tag,
  output logic              r1_valid,
  output logic [DATA_W-1:0] r1_data,
  output logic [TAG_W-1:0]  r1_tag
);

  localparam int NL = 2;

  logic phase_q;

  logic              ln_take [NL];
  logic [2:0]        ln_op   [NL];
  logic [DATA_W-1:0] ln_a    [NL];
  logic [DATA_W-1:0] ln_b    [NL];
  logic [TAG_W-1:0]  ln_tag  [NL];
  logic              ln_dep  [NL];
  logic [DATA_W-1:0] ln_half [NL];
  logic              ln_v    [NL];
  logic [DATA_W-1:0] ln_d    [NL];
  logic [TAG_W-1:0]  ln_t    [NL];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign half_phase = phase_q;

  dpa_issue_gate u_gate (
    .s0_valid (s0_valid),
    .s0_op    (s0_op),
    .s1_op    (s1_op),
    .s1_dep   (s1_dep),
    .s1_ready (s1_ready)
  );

  assign ln_take[0] = s0_valid;
  assign ln_op[0]   = s0_op;
  assign ln_a[0]    = s0_a;
  assign ln_b[0]    = s0_b;
  assign ln_tag[0]  = s0_tag;
  assign ln_dep[0]  = 1'b0;

  assign ln_take[1] = s1_valid && s1_ready;
  assign ln_op[1]   = s1_op;
  assign ln_a[1]    = s1_a;
  assign ln_b[1]    = s1_b;
  assign ln_tag[1]  = s1_tag;
  assign ln_dep[1]  = s1_dep;

  // Each lane's forward input is the other lane's half result; lane 0 never
  // takes a dependency, so only lane 1 consumes it.
  for (genvar i = 0; i < NL; i++) begin : g_lane
    dpa_lane #(.W(DATA_W), .TAG_W(TAG_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .second_half (phase_q),
      .take        (ln_take[i]),
      .op          (ln_op[i]),
      .a           (ln_a[i]),
      .b           (ln_b[i]),
      .tag         (ln_tag[i]),
      .dep         (ln_dep[i]),
      .fwd_data    (ln_half[(i + 1) % NL]),
      .half_res    (ln_half[i]),
      .out_valid   (ln_v[i]),
      .out_data    (ln_d[i]),
      .out_tag     (ln_t[i])
    );
  end

  assign r0_valid = ln_v[0];
  assign r0_data  = ln_d[0];
  assign r0_tag   = ln_t[0];
  assign r1_valid = ln_v[1];
  assign r1_data  = ln_d[1];
  assign r1_tag   = ln_t[1];

  assert_phase_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (phase_q != $past(phase_q)));

  assert_indep_R6: assert property (@(posedge clk) disable iff (rst)
    !s1_dep |-> s1_ready);

endmodule

// File: tb/dual_pump_alu_test.sv
module dual_pump_alu_test;

  localparam int W  = 32;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          s0_valid, s1_valid, s1_dep;
  logic [2:0]    s0_op, s1_op;
  logic [W-1:0]  s0_a, s0_b, s1_a, s1_b;
  logic [TW-1:0] s0_tag, s1_tag;
  logic          s1_ready, half_phase;
  logic          r0_valid, r1_valid;
  logic [W-1:0]  r0_data, r1_data;
  logic [TW-1:0] r0_tag, r1_tag;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic          v0;
    logic [W-1:0]  d0;
    logic [TW-1:0] t0;
    logic          v1;
    logic [W-1:0]  d1;
    logic [TW-1:0] t1;
    string         req;
  } exp_t;

  exp_t hist0, hist1, idle_e;

  always #5 clk = ~clk;

  dual_pump_alu uut (
    .clk(clk), .rst(rst),
    .s0_valid(s0_valid), .s0_op(s0_op), .s0_a(s0_a), .s0_b(s0_b), .s0_tag(s0_tag),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_a(s1_a), .s1_b(s1_b), .s1_tag(s1_tag),
    .s1_dep(s1_dep), .s1_ready(s1_ready), .half_phase(half_phase),
    .r0_valid(r0_valid), .r0_data(r0_data), .r0_tag(r0_tag),
    .r1_valid(r1_valid), .r1_data(r1_data), .r1_tag(r1_tag)
  );

  function automatic logic [W-1:0] ref_op(input logic [2:0] op, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return a >> b[4:0];
      default: return a;
    endcase
  endfunction

  function automatic logic is_sh(input logic [2:0] op);
    return (op == 3'd5) || (op == 3'd6);
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input exp_t e);
    chk("R1", "r0_valid", {31'd0, r0_valid}, {31'd0, e.v0});
    if (e.v0) begin
      chk(e.req, "r0_data", r0_data, e.d0);
      chk("R1", "r0_tag", {26'd0, r0_tag}, {26'd0, e.t0});
    end
    chk("R1", "r1_valid", {31'd0, r1_valid}, {31'd0, e.v1});
    if (e.v1) begin
      chk(e.req, "r1_data", r1_data, e.d1);
      chk("R1", "r1_tag", {26'd0, r1_tag}, {26'd0, e.t1});
    end
  endtask

  // Called at a negedge in the second half; returns at the next such negedge.
  task automatic issue(input logic v0, input logic [2:0] op0, input logic [W-1:0] a0,
                       input logic [W-1:0] b0, input logic [TW-1:0] t0,
                       input logic v1, input logic [2:0] op1, input logic [W-1:0] a1,
                       input logic [W-1:0] b1, input logic [TW-1:0] t1,
                       input logic dep, input string req);
    exp_t e;
    logic rdy;
    chk("R7", "half_phase second", {31'd0, half_phase}, 32'd1);
    s0_valid = v0; s0_op = op0; s0_a = a0; s0_b = b0; s0_tag = t0;
    s1_valid = v1; s1_op = op1; s1_a = a1; s1_b = b1; s1_tag = t1; s1_dep = dep;
    #1;
    rdy = !(dep && (!v0 || is_sh(op0) || is_sh(op1)));
    chk(dep ? "R5" : "R6", "s1_ready", {31'd0, s1_ready}, {31'd0, rdy});
    check_out(hist1);
    e.v0 = v0; e.d0 = ref_op(op0, a0, b0); e.t0 = t0;
    e.v1 = v1 && rdy;
    e.d1 = dep ? ref_op(op1, e.d0, b1) : ref_op(op1, a1, b1);
    e.t1 = t1; e.req = req;
    hist1 = hist0;
    hist0 = e;
    @(negedge clk);
    chk("R7", "half_phase first", {31'd0, half_phase}, 32'd0);
    check_out(hist1);
    @(negedge clk);
  endtask

  task automatic idle();
    issue(1'b0, 3'd0, '0, '0, '0, 1'b0, 3'd0, '0, '0, '0, 1'b0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_e.v0 = 1'b0; idle_e.d0 = '0; idle_e.t0 = '0;
    idle_e.v1 = 1'b0; idle_e.d1 = '0; idle_e.t1 = '0; idle_e.req = "R1";
    hist0 = idle_e; hist1 = idle_e;
    rst = 1'b1;
    s0_valid = 0; s0_op = 0; s0_a = 0; s0_b = 0; s0_tag = 0;
    s1_valid = 0; s1_op = 0; s1_a = 0; s1_b = 0; s1_tag = 0; s1_dep = 0;
    repeat (3) @(negedge clk);
    chk("R8", "r0_valid in reset", {31'd0, r0_valid}, 32'd0);
    chk("R8", "r1_valid in reset", {31'd0, r1_valid}, 32'd0);
    chk("R8", "half_phase in reset", {31'd0, half_phase}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2: simple opcodes on both lanes
    issue(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 6'd1, 1, 3'd1, 32'd0, 32'd1, 6'd2, 0, "R2");
    issue(1, 3'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 6'd3, 1, 3'd3, 32'hA000_0001, 32'h0500_0010, 6'd4, 0, "R2");
    issue(1, 3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 6'd5, 1, 3'd7, 32'hCAFE_BABE, 32'h1111_1111, 6'd6, 0, "R2");
    // R3: shift amounts at max and zero, upper B bits set
    issue(1, 3'd5, 32'h0000_0003, 32'hFFFF_FFFF, 6'd7, 1, 3'd6, 32'h8000_0001, 32'hFFFF_FFE0, 6'd8, 0, "R3");
    issue(1, 3'd6, 32'h8000_0000, 32'h0000_0124, 6'd9, 1, 3'd5, 32'h0000_00FF, 32'h0000_0008, 6'd10, 0, "R3");
    // R4: dependent simple pair, slot 1 A field is a decoy
    issue(1, 3'd0, 32'd100, 32'd23, 6'd11, 1, 3'd1, 32'hDEAD_BEEF, 32'd3, 6'd12, 1, "R4");
    issue(1, 3'd4, 32'hFFFF_FFFF, 32'h0000_FFFF, 6'd13, 1, 3'd2, 32'h0, 32'hFF00_FF00, 6'd14, 1, "R4");
    // R5: each refusal condition
    issue(1, 3'd5, 32'd1, 32'd4, 6'd15, 1, 3'd0, 32'd5, 32'd6, 6'd16, 1, "R5");
    issue(1, 3'd0, 32'd1, 32'd4, 6'd17, 1, 3'd6, 32'd5, 32'd1, 6'd18, 1, "R5");
    issue(0, 3'd0, 32'd1, 32'd4, 6'd19, 1, 3'd0, 32'd5, 32'd6, 6'd20, 1, "R5");
    // R6: independent shifts on both lanes never stall
    issue(1, 3'd6, 32'hF000_0000, 32'd28, 6'd21, 1, 3'd5, 32'd1, 32'd31, 6'd22, 0, "R6");
    idle();
    idle();

    // R9: back-to-back random pairs
    for (int n = 0; n < 400; n++) begin
      logic [2:0] o0, o1;
      logic [W-1:0] b0, b1;
      o0 = 3'($urandom);
      o1 = 3'($urandom);
      b0 = ($urandom % 2) ? 32'($urandom % 40) : 32'($urandom);
      b1 = ($urandom % 2) ? 32'($urandom % 40) : 32'($urandom);
      issue(($urandom % 4) != 0, o0, 32'($urandom), b0, 6'($urandom),
            ($urandom % 4) != 0, o1, 32'($urandom), b1, 6'($urandom),
            ($urandom % 3) == 0, "R9");
    end
    idle();
    idle();

    // R8: reset while operations are in flight
    issue(1, 3'd0, 32'd7, 32'd8, 6'd30, 1, 3'd3, 32'd1, 32'd2, 6'd31, 0, "R8");
    rst = 1'b1;
    @(negedge clk);
    chk("R8", "r0_valid after reset", {31'd0, r0_valid}, 32'd0);
    chk("R8", "r1_valid after reset", {31'd0, r1_valid}, 32'd0);
    chk("R8", "half_phase after reset", {31'd0, half_phase}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    hist0 = idle_e;
    hist1 = idle_e;
    idle();
    idle();
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule